// File: doc/BRIEF.md
# Gated Scan Strobe Generator

This block issues the scan-start strobe that paces a multichannel acquisition engine. Each strobe is one clock wide. It comes either from an internal reloading interval timer or from rising edges on an external scan line; one configuration bit selects the source. A start trigger opens an acquisition sequence and loads both the interval timer and a sample counter. The sequence closes when the sample counter has delivered its last scan or when software issues a stop, whichever comes first.

A strobe reaches the output only while a sequence is open and not paused. A pause comes from one gate, selected by configuration: either a hardware gate pin or a software gate bit. A strobe that arrives outside a sequence or while paused is discarded and is never delivered later. The start trigger, the hardware gate and the external scan line are asynchronous. Each one passes through a two-flop synchronizer before use. The stop, gate and configuration inputs are synchronous register bits.

Control is a four-state machine:
- IDLE: after reset.
- RUN: sequence open, gate clear.
- PAUSE: sequence open, gate set.
- DONE: sequence closed.

Its transitions are:
- start (IDLE or DONE to RUN, or to PAUSE if the gate is already set).
- hold (RUN to PAUSE when the gate sets).
- resume (PAUSE to RUN when the gate clears).
- finish (RUN or PAUSE to DONE, on a software stop or on delivery of the last sample).

Top module: `scan_strobe_gen`

## Requirements
- R1: After reset, scan_out, seq_active and done are all 0.
- R2: When start_trig goes high, seq_active goes high on the third rising clock edge after that.
- R3: With the internal source selected (cfg_ext_src=0), the first scan_out pulse comes cfg_interval+1 cycles after seq_active rises. Later pulses are spaced exactly cfg_interval+1 cycles apart.
- R4: With the external source selected (cfg_ext_src=1), each rising edge of ext_scan gives exactly one one-cycle scan_out pulse, on the third rising clock edge after the edge, and the internal timer produces no pulses. A level held high gives only that one pulse.
- R5: No scan_out pulse appears while no sequence is open. This holds for both sources.
- R6: cfg_gate_hw=1 selects gate_in as the gate, and cfg_gate_hw=0 selects sw_gate. A high level on the selected gate suppresses scan_out while the sequence stays open. The unselected gate has no effect. Suppressed strobes are not delivered later.
- R7: A sequence delivers exactly cfg_samples scans (a preset of 0 acts as 1). Then seq_active falls and done rises on the same edge that registers the last pulse.
- R8: sw_stop high for one cycle while a sequence is open closes it on the next edge (done=1, seq_active=0). A strobe due in that same cycle is dropped.
- R9: A start trigger while a sequence is open is ignored: neither the timer phase nor the sample count is reloaded.
- R10: done stays high until the next sequence starts, and it is 0 when seq_active rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_src | input | 1 | 1 selects the external scan line as the source, 0 selects the internal timer |
| cfg_gate_hw | input | 1 | 1 selects gate_in as the pause gate, 0 selects sw_gate |
| cfg_interval | input | CNT_W | Internal timer reload value; the period is this value plus one |
| cfg_samples | input | CNT_W | Number of scans per sequence |
| sw_gate | input | 1 | Software pause bit (active high) |
| sw_stop | input | 1 | Software stop command (one-cycle pulse) |
| start_trig | input | 1 | Asynchronous start trigger (rising edge) |
| gate_in | input | 1 | Asynchronous hardware pause gate (active high) |
| ext_scan | input | 1 | Asynchronous external scan line (rising edge) |
| scan_out | output | 1 | One-cycle scan-start strobe |
| seq_active | output | 1 | Sequence open (RUN or PAUSE) |
| done | output | 1 | Sequence closed (DONE) |

## Verification
Two events can land in the same clock cycle: a software stop and a timer strobe. The bench provokes this by counting edges from the start of a sequence and raising sw_stop in the exact cycle the timer reaches zero. The correct result is a closed sequence with no pulse at all. A design that let the strobe through would show one pulse. The other case of the same kind is delivery of the last sample. That delivery must both emit its pulse and close the sequence on one edge, and it is judged by the exact pulse count together with done.

// File: rtl/scg_pkg.sv
package scg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_PAUSE,
        ST_DONE
    } scg_state_e;
endpackage

// File: rtl/scg_sync.sv
module scg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scg_interval_timer.sv
module scg_interval_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= reload;
        else if (run) begin
            if (cnt == '0)      cnt <= reload;
            else                cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && !load && (cnt == '0);

    // R3
    reload_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(reload)));
endmodule

// File: rtl/scg_sample_counter.sv
module scg_sample_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (load)                  cnt <= preset;
        else if (dec && cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign last = (cnt <= CNT_W'(1));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && $past(cnt) == '0 && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/scan_strobe_gen.sv
module scan_strobe_gen
    import scg_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ext_src,
    input  logic             cfg_gate_hw,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic [CNT_W-1:0] cfg_samples,
    input  logic             sw_gate,
    input  logic             sw_stop,
    input  logic             start_trig,
    input  logic             gate_in,
    input  logic             ext_scan,
    output logic             scan_out,
    output logic             seq_active,
    output logic             done
);
    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] async_q;
    logic start_s, gate_s, ext_s;
    logic start_d, ext_d;
    logic start_rise, ext_rise;
    logic gate_now, active, tick, last, src_strobe, deliver, load;
    scg_state_e state, state_nx;

    scg_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_scan, gate_in, start_trig}),
        .q     (async_q)
    );
    assign {ext_s, gate_s, start_s} = async_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_d <= 1'b0;
            ext_d   <= 1'b0;
        end else begin
            start_d <= start_s;
            ext_d   <= ext_s;
        end
    end

    assign start_rise = start_s && !start_d;
    assign ext_rise   = ext_s && !ext_d;
    assign gate_now   = cfg_gate_hw ? gate_s : sw_gate;
    assign active     = (state == ST_RUN) || (state == ST_PAUSE);
    assign load       = start_rise && !active;
    assign src_strobe = cfg_ext_src ? ext_rise : tick;
    assign deliver    = active && src_strobe && !gate_now && !sw_stop;

    scg_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (active),
        .load   (load),
        .reload (cfg_interval),
        .tick   (tick)
    );

    scg_sample_counter #(.CNT_W(CNT_W)) u_samples (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .preset (cfg_samples),
        .dec    (deliver),
        .last   (last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start_rise) state_nx = gate_now ? ST_PAUSE : ST_RUN;
            end
            ST_RUN: begin
                if (sw_stop || (deliver && last)) state_nx = ST_DONE;
                else if (gate_now)                state_nx = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (sw_stop || (deliver && last)) state_nx = ST_DONE;
                else if (!gate_now)               state_nx = ST_RUN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_out <= 1'b0;
        else        scan_out <= deliver;
    end

    assign seq_active = active;
    assign done       = (state == ST_DONE);

    // R5
    scan_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out |-> $past(seq_active));

    // R8
    stop_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stop && seq_active) |=> (done && !seq_active && !scan_out));

    // R7
    last_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && last) |=> (done && scan_out));

    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_active) |-> !done);
endmodule

// File: tb/scan_strobe_gen_test.sv
module scan_strobe_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ext_src = 1'b0, cfg_gate_hw = 1'b0;
    logic [CW-1:0] cfg_interval = '0, cfg_samples = '0;
    logic sw_gate = 1'b0, sw_stop = 1'b0;
    logic start_trig = 1'b0, gate_in = 1'b0, ext_scan = 1'b0;
    logic scan_out, seq_active, done;

    scan_strobe_gen #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_ext_src(cfg_ext_src), .cfg_gate_hw(cfg_gate_hw),
        .cfg_interval(cfg_interval), .cfg_samples(cfg_samples), .sw_gate(sw_gate),
        .sw_stop(sw_stop), .start_trig(start_trig), .gate_in(gate_in), .ext_scan(ext_scan),
        .scan_out(scan_out), .seq_active(seq_active), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    int total = 0, fails = 0;
    int pulses = 0, last_t = -1, min_sp = 0, max_sp = 0, first_t = -1, act_t = -1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (seq_active && act_t < 0) act_t = cyc;
        if (scan_out === 1'b1) begin
            pulses = pulses + 1;
            if (first_t < 0) first_t = cyc;
            if (last_t >= 0) begin
                if (min_sp == 0 || cyc - last_t < min_sp) min_sp = cyc - last_t;
                if (cyc - last_t > max_sp) max_sp = cyc - last_t;
            end
            last_t = cyc;
        end
    end

    typedef struct packed {
        logic [CW-1:0] interval;
        logic [CW-1:0] samples;
        logic [31:0]   exp_pulses;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{24'd0, 24'd5, 32'd5},
        '{24'd3, 24'd4, 32'd4},
        '{24'd7, 24'd3, 32'd3},
        '{24'd2, 24'd0, 32'd1},
        '{24'd1, 24'd1, 32'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        pulses = 0; last_t = -1; min_sp = 0; max_sp = 0; first_t = -1; act_t = -1;
    endtask

    task automatic start_seq();
        @(negedge clk) start_trig = 1'b1;
        repeat (3) @(negedge clk);
        start_trig = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
    endtask

    task automatic stop_pulse();
        @(negedge clk) sw_stop = 1'b1;
        @(negedge clk) sw_stop = 1'b0;
    endtask

    task automatic ext_pulse();
        @(negedge clk) ext_scan = 1'b1;
        repeat (3) @(negedge clk);
        ext_scan = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(scan_out == 1'b0 && seq_active == 1'b0 && done == 1'b0, "R1 reset outputs",
            {scan_out, seq_active, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5: external edges before any sequence are dropped
        cfg_ext_src = 1'b1;
        clear_mon();
        ext_pulse();
        ext_pulse();
        chk(pulses == 0, "R5 no scan outside sequence", pulses, 0);

        // Vector table, internal source
        cfg_ext_src = 1'b0;
        for (int i = 0; i < 5; i++) begin
            cfg_interval = VECS[i].interval;
            cfg_samples  = VECS[i].samples;
            clear_mon();
            @(negedge clk) start_trig = 1'b1;
            @(negedge clk);
            @(negedge clk);
            chk(seq_active == 1'b0, "R2 not active before third edge", seq_active, 0);
            @(negedge clk);
            start_trig = 1'b0;
            chk(seq_active == 1'b1, "R2 active on third edge", seq_active, 1);
            if (i > 0) chk(done == 1'b0, "R10 done cleared at new start", done, 0);
            wait_done();
            repeat (12) @(negedge clk);
            chk(pulses == int'(VECS[i].exp_pulses), "R7 scan count", pulses, int'(VECS[i].exp_pulses));
            chk(done == 1'b1 && seq_active == 1'b0, "R7 sequence closed", {done, seq_active}, 2);
            chk(first_t - act_t == int'(VECS[i].interval) + 1, "R3 first pulse latency",
                first_t - act_t, int'(VECS[i].interval) + 1);
            if (VECS[i].exp_pulses > 1)
                chk(min_sp == int'(VECS[i].interval) + 1 && max_sp == min_sp, "R3 pulse spacing",
                    max_sp, int'(VECS[i].interval) + 1);
        end

        // R4 external source latency; internal timer at interval 0 must not fire
        cfg_ext_src = 1'b1; cfg_interval = '0; cfg_samples = 24'd3;
        clear_mon();
        start_seq();
        repeat (5) @(negedge clk);
        chk(pulses == 0, "R4 internal timer unused", pulses, 0);
        ext_scan = 1'b1;
        @(negedge clk);
        @(negedge clk); chk(scan_out == 1'b0, "R4 no pulse after two edges", scan_out, 0);
        @(negedge clk); chk(scan_out == 1'b1, "R4 pulse on third edge", scan_out, 1);
        @(negedge clk); chk(scan_out == 1'b0, "R4 one-cycle pulse", scan_out, 0);
        repeat (4) @(negedge clk);
        chk(pulses == 1, "R4 held level gives one pulse", pulses, 1);
        ext_scan = 1'b0;
        repeat (3) @(negedge clk);
        ext_pulse();
        ext_pulse();
        chk(pulses == 3 && done == 1'b1, "R7 external sequence ends after preset", pulses, 3);

        // R6 hardware gate selected
        cfg_ext_src = 1'b0; cfg_interval = 24'd1; cfg_samples = 24'd1000;
        cfg_gate_hw = 1'b1; gate_in = 1'b1; sw_gate = 1'b0;
        clear_mon();
        start_seq();
        repeat (30) @(negedge clk);
        chk(pulses == 0 && seq_active == 1'b1, "R6 hardware gate pauses", pulses, 0);
        gate_in = 1'b0;
        clear_mon();
        repeat (20) @(negedge clk);
        chk(pulses >= 7 && pulses <= 11, "R6 dropped scans not queued", pulses, 9);
        sw_gate = 1'b1;
        clear_mon();
        repeat (20) @(negedge clk);
        chk(pulses >= 9, "R6 unselected software gate ignored", pulses, 10);
        sw_gate = 1'b0;
        stop_pulse();
        chk(done == 1'b1 && seq_active == 1'b0, "R8 stop closes sequence", {done, seq_active}, 2);
        clear_mon();
        repeat (10) @(negedge clk);
        chk(pulses == 0, "R8 no pulses after stop", pulses, 0);

        // R6 software gate selected
        cfg_gate_hw = 1'b0; sw_gate = 1'b1; gate_in = 1'b0;
        clear_mon();
        start_seq();
        repeat (20) @(negedge clk);
        chk(pulses == 0 && seq_active == 1'b1, "R6 software gate pauses", pulses, 0);
        sw_gate = 1'b0; gate_in = 1'b1;
        clear_mon();
        repeat (20) @(negedge clk);
        chk(pulses >= 9, "R6 unselected hardware gate ignored", pulses, 10);
        gate_in = 1'b0;
        stop_pulse();

        // R8 stop in the same cycle as a timer strobe
        cfg_interval = 24'd4; cfg_samples = 24'd100;
        clear_mon();
        start_seq();
        repeat (4) @(negedge clk);
        sw_stop = 1'b1;
        @(negedge clk) sw_stop = 1'b0;
        repeat (10) @(negedge clk);
        chk(pulses == 0, "R8 colliding strobe dropped", pulses, 0);
        chk(done == 1'b1, "R8 done after colliding stop", done, 1);

        // R9 start while running is ignored
        cfg_interval = 24'd5; cfg_samples = 24'd6;
        clear_mon();
        start_seq();
        repeat (9) @(negedge clk);
        start_seq();
        wait_done();
        repeat (10) @(negedge clk);
        chk(pulses == 6, "R9 sample count not reloaded", pulses, 6);
        chk(min_sp == 6 && max_sp == 6, "R9 timer phase kept", max_sp, 6);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule